// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Unit

This block watches general-purpose input pins arranged in three groups of up to eight and raises one interrupt request per group when any enabled pin in that group toggles. Each pin is brought into the clock domain through a two-flop synchronizer. A change is detected by comparing two consecutive synchronized samples. Changes on pins whose mask bit is set are OR-reduced into a single sticky flag per group.

Software reaches the block through a byte-wide register port with these registers: one mask register per group, a group enable register and a group flag register. A flag is cleared by writing a one to its bit, or by a per-group acknowledge from the interrupt controller. A request leaves the block only when the global interrupt enable, the group enable and the group flag are all set. When several requests are active, a priority encoder reports the lowest-numbered group.

Each group flag is a two-state machine:
- The states are S_IDLE and S_PENDING.
- The catch transition (S_IDLE to S_PENDING) is taken on any masked change.
- The clear transition (S_PENDING to S_IDLE) is taken on a write-one or an acknowledge, but only in a cycle with no masked change.
- In every other case the state holds.

Group 1 has seven usable pins (pins 8 to 14). Pin 15 is never observed.

Top module: `pcint_unit`

## Requirements
- R1: After reset every register reads zero, and `irq_req` and `irq_valid` are zero.
- R2: Register addresses are:
  - 0: group enable, bits 2:0.
  - 1: group flags, bits 2:0.
  - 2, 3 and 4: mask registers for groups 0, 1 and 2.
  A written mask reads back unchanged, except that bit 7 of the group 1 mask always reads zero.
- R3: A rising or a falling change on a pin whose mask bit is set sets that group's flag bit. The flag is visible in the flag register after the third rising clock edge following the pin change. Flag register bits 7:3 always read zero.
- R4: A change on a pin whose mask bit is clear does not set a flag. A change on pin 15 never sets a flag.
- R5: A flag is set by a masked change even while the group enable bit is zero.
- R6: Writing the flag register clears each flag whose written bit is one and leaves flags whose written bit is zero.
- R7: A one on `ack[g]` for one cycle clears group g's flag.
- R8: A masked change detected in the same cycle as a clearing write or acknowledge leaves the flag set.
- R9: `irq_req[g]` is one exactly when `gie`, the enable bit of group g and the flag of group g are all one.
- R10: `irq_valid` is the OR of `irq_req`. `irq_id` gives the lowest-numbered requesting group, so group 0 has the highest priority.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins | input | 24 | Monitored pins; bit 15 unused |
| addr | input | 3 | Register address for read and write |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data at `addr` |
| gie | input | 1 | Global interrupt enable |
| ack | input | 3 | Per-group acknowledge, clears the flag |
| irq_req | output | 3 | Per-group request |
| irq_valid | output | 1 | Any request active |
| irq_id | output | 2 | Highest-priority requesting group |

## Verification
A group flag stuck in S_PENDING, or one that missed the catch transition, shows in the flag register on the next read. With the enables set, it also shows on `irq_req` in the same cycle. A wrong synchronizer depth moves the flag edge off the third rising edge after the pin change, which the bench samples exactly. A wrong order between clear and catch appears one cycle after the colliding write as a zero flag. A priority error shows on `irq_id` as soon as two flags are pending together.

// File: rtl/pcint_pkg.sv
package pcint_pkg;
    localparam int GROUPS      = 3;
    localparam int GRP_W       = 8;
    localparam int PIN_W       = GROUPS * GRP_W;
    localparam int ADDR_W      = 3;
    localparam int ID_W        = $clog2(GROUPS);
    localparam int SHORT_GROUP = 1;
    localparam int SHORT_W     = 7;

    localparam logic [ADDR_W-1:0] A_ENABLE    = 3'd0;
    localparam logic [ADDR_W-1:0] A_FLAGS     = 3'd1;
    localparam logic [ADDR_W-1:0] A_MASK_BASE = 3'd2;

    typedef enum logic {
        S_IDLE,
        S_PENDING
    } flag_state_e;

    function automatic logic [GRP_W-1:0] usable_bits(input int g);
        if (g == SHORT_GROUP)
            return GRP_W'((1 << SHORT_W) - 1);
        else
            return '1;
    endfunction
endpackage

// File: rtl/pcint_sync.sv
module pcint_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/pcint_group.sv
module pcint_group #(
    parameter int              W    = 8,
    parameter logic [W-1:0]    USED = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_s,
    input  logic         mask_we,
    input  logic [W-1:0] mask_wd,
    input  logic         clr,
    output logic [W-1:0] mask_q,
    output logic         flag
);
    import pcint_pkg::*;

    logic [W-1:0] prev_q;
    logic         hit;
    flag_state_e  state_q, state_d;

    // Edge of either polarity on an enabled pin.
    assign hit = |((pin_s ^ prev_q) & mask_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            mask_q <= '0;
        end else begin
            prev_q <= pin_s;
            if (mask_we)
                mask_q <= mask_wd & USED;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state: catch beats clear
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (hit)         state_d = S_PENDING;
            S_PENDING: if (clr && !hit) state_d = S_IDLE;
            default:                    state_d = S_IDLE;
        endcase
    end

    // Output
    always_comb begin
        flag = 1'b0;
        unique case (state_q)
            S_IDLE:    flag = 1'b0;
            S_PENDING: flag = 1'b1;
            default:   flag = 1'b0;
        endcase
    end
endmodule

// File: rtl/pcint_unit.sv
module pcint_unit (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [pcint_pkg::PIN_W-1:0]     pins,
    input  logic [pcint_pkg::ADDR_W-1:0]    addr,
    input  logic                            wr_en,
    input  logic [pcint_pkg::GRP_W-1:0]     wdata,
    output logic [pcint_pkg::GRP_W-1:0]     rd_data,
    input  logic                            gie,
    input  logic [pcint_pkg::GROUPS-1:0]    ack,
    output logic [pcint_pkg::GROUPS-1:0]    irq_req,
    output logic                            irq_valid,
    output logic [pcint_pkg::ID_W-1:0]      irq_id
);
    import pcint_pkg::*;

    logic [PIN_W-1:0]                pins_s;
    logic [GROUPS-1:0]               en_q;
    logic [GROUPS-1:0]               flags;
    logic [GROUPS-1:0][GRP_W-1:0]    masks;

    pcint_sync #(.W(PIN_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins),
        .q     (pins_s)
    );

    generate
        for (genvar g = 0; g < GROUPS; g++) begin : g_grp
            localparam logic [ADDR_W-1:0] MADDR = A_MASK_BASE + ADDR_W'(g);
            logic mwe, fclr;
            assign mwe  = wr_en && (addr == MADDR);
            assign fclr = (wr_en && (addr == A_FLAGS) && wdata[g]) || ack[g];

            pcint_group #(.W(GRP_W), .USED(usable_bits(g))) u_grp (
                .clk     (clk),
                .rst_n   (rst_n),
                .pin_s   (pins_s[g*GRP_W +: GRP_W]),
                .mask_we (mwe),
                .mask_wd (wdata),
                .clr     (fclr),
                .mask_q  (masks[g]),
                .flag    (flags[g])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            en_q <= '0;
        else if (wr_en && addr == A_ENABLE)
            en_q <= wdata[GROUPS-1:0];
    end

    always_comb begin
        rd_data = '0;
        if (addr == A_ENABLE)
            rd_data[GROUPS-1:0] = en_q;
        else if (addr == A_FLAGS)
            rd_data[GROUPS-1:0] = flags;
        else begin
            for (int g = 0; g < GROUPS; g++)
                if (addr == A_MASK_BASE + ADDR_W'(g))
                    rd_data = masks[g];
        end
    end

    assign irq_req   = flags & en_q & {GROUPS{gie}};
    assign irq_valid = |irq_req;

    always_comb begin
        irq_id = '0;
        for (int g = GROUPS - 1; g >= 0; g--)
            if (irq_req[g])
                irq_id = ID_W'(g);
    end
endmodule

// File: rtl/pcint_unit_chk.sv
module pcint_unit_chk (
    input logic                            clk,
    input logic                            rst_n,
    input logic [pcint_pkg::PIN_W-1:0]     pins,
    input logic [pcint_pkg::ADDR_W-1:0]    addr,
    input logic                            wr_en,
    input logic [pcint_pkg::GRP_W-1:0]     wdata,
    input logic [pcint_pkg::GRP_W-1:0]     rd_data,
    input logic                            gie,
    input logic [pcint_pkg::GROUPS-1:0]    ack,
    input logic [pcint_pkg::GROUPS-1:0]    irq_req,
    input logic                            irq_valid,
    input logic [pcint_pkg::ID_W-1:0]      irq_id
);
    import pcint_pkg::*;

    a_r9_req_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_req) |-> gie);

    a_r3_flag_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_FLAGS) |-> (rd_data[GRP_W-1:GROUPS] == '0));

    a_r2_short_mask_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_MASK_BASE + ADDR_W'(SHORT_GROUP)) |-> (rd_data[GRP_W-1] == 1'b0));

    a_r10_valid_matches: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid == (irq_req != '0));

    a_r10_priority: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_req[irq_id] &&
                       ((irq_req & ((GROUPS'(1) << irq_id) - GROUPS'(1))) == '0)));

    generate
        for (genvar g = 0; g < GROUPS; g++) begin : g_fall
            a_r7_req_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(irq_req[g]) |-> (!gie || $past(ack[g]) || $past(wr_en)));
        end
    endgenerate
endmodule

bind pcint_unit pcint_unit_chk u_chk (.*);

// File: tb/tb_pcint_unit.sv
`timescale 1ns/1ps
module tb_pcint_unit;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [23:0] pins = '0;
    logic [2:0]  addr = '0;
    logic        wr_en = 0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rd_data;
    logic        gie = 0;
    logic [2:0]  ack = '0;
    logic [2:0]  irq_req;
    logic        irq_valid;
    logic [1:0]  irq_id;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pcint_unit dut (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        addr = a;
        #1;
        check(tag, rd_data, exp);
    endtask

    task automatic toggle_pin(input int idx);
        @(negedge clk);
        pins[idx] = ~pins[idx];
        repeat (3) @(posedge clk);
    endtask

    task automatic t_reset;
        for (int a = 0; a < 5; a++) rd_chk(3'(a), 8'h00, "R1 reset reg");
        check("R1 reset irq_valid", irq_valid, 0);
        check("R1 reset irq_req", irq_req, 0);
    endtask

    task automatic t_mask_rw;
        wr(3'd2, 8'hA5); rd_chk(3'd2, 8'hA5, "R2 mask0");
        wr(3'd3, 8'hFF); rd_chk(3'd3, 8'h7F, "R2 mask1 top bit");
        wr(3'd4, 8'h3C); rd_chk(3'd4, 8'h3C, "R2 mask2");
    endtask

    task automatic t_change;
        wr(3'd2, 8'h01);
        toggle_pin(0);
        rd_chk(3'd1, 8'h01, "R3 rising sets flag, R5 enable clear");
        check("R5 no request while disabled", irq_valid, 0);
        wr(3'd1, 8'h00); rd_chk(3'd1, 8'h01, "R6 write zero keeps flag");
        wr(3'd1, 8'h01); rd_chk(3'd1, 8'h00, "R6 write one clears flag");
        toggle_pin(0);
        rd_chk(3'd1, 8'h01, "R3 falling sets flag");
        wr(3'd1, 8'h07);
    endtask

    task automatic t_masked;
        toggle_pin(1);
        rd_chk(3'd1, 8'h00, "R4 masked pin ignored");
        wr(3'd3, 8'h7F);
        toggle_pin(15);
        rd_chk(3'd1, 8'h00, "R4 pin 15 ignored");
        toggle_pin(15);
    endtask

    task automatic t_request;
        wr(3'd0, 8'h07);
        toggle_pin(0);
        @(negedge clk);
        check("R9 gie low blocks", irq_req, 3'b000);
        gie = 1;
        #1;
        check("R9 request asserted", irq_req, 3'b001);
        check("R10 id group0", irq_id, 0);
        @(negedge clk); ack = 3'b001;
        @(negedge clk); ack = 3'b000;
        #1;
        check("R7 ack clears request", irq_req, 3'b000);
        rd_chk(3'd1, 8'h00, "R7 ack clears flag");
    endtask

    task automatic t_priority;
        wr(3'd4, 8'h01);
        toggle_pin(8);
        toggle_pin(16);
        @(negedge clk);
        check("R10 two pending id", irq_id, 1);
        check("R10 valid", irq_valid, 1);
        toggle_pin(0);
        @(negedge clk);
        check("R10 group0 wins", irq_id, 0);
        check("R9 all requests", irq_req, 3'b111);
        ack = 3'b001; @(negedge clk); ack = 3'b000; #1;
        check("R10 next group1", irq_id, 1);
        ack = 3'b010; @(negedge clk); ack = 3'b000; #1;
        check("R10 last group2", irq_id, 2);
        ack = 3'b100; @(negedge clk); ack = 3'b000; #1;
        check("R10 none left", irq_valid, 0);
    endtask

    task automatic t_collide;
        toggle_pin(0);
        // Flag set; new change detected in cycle when clear write lands.
        @(negedge clk);
        pins[0] = ~pins[0];
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        addr = 3'd1; wdata = 8'h01; wr_en = 1;
        @(negedge clk);
        wr_en = 0;
        rd_chk(3'd1, 8'h01, "R8 event beats write clear");
        @(negedge clk);
        pins[0] = ~pins[0];
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        ack = 3'b001;
        @(negedge clk);
        ack = 3'b000;
        rd_chk(3'd1, 8'h01, "R8 event beats ack");
        wr(3'd1, 8'h01);
        rd_chk(3'd1, 8'h00, "R6 clear after collision");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        t_reset;
        t_mask_rw;
        t_change;
        t_masked;
        t_request;
        t_priority;
        t_collide;
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule